// File: doc/BRIEF.md
# Interrupt Redirection and Delivery Engine

This block sits between a bank of external interrupt request lines and the fabric that carries interrupt messages to processors. Every pin owns a redirection entry that states where its interrupts go and how they behave: target vector, delivery mode, destination and destination mode, input polarity, edge or level triggering, and a mask. Incoming lines are conditioned by polarity and trigger type into a per-pin pending register. A scanner then picks the lowest-numbered pin that may be delivered and places one delivery message at a time on a valid/ready output.

Level-triggered pins use a per-entry in-service flag. It is set when the pin is delivered and cleared only by an end-of-interrupt broadcast that carries the same vector, so a level source that is still asserted is not delivered again until software has acknowledged it. Edge-triggered pins have no such flag. Their pending bit is consumed by the delivery. Entries are loaded through a plain write port. The register bus that normally drives that port lies outside this block.

Top module: `irq_redirect_engine`

## Requirements
- R1: After a synchronous active-low reset, `dlv_valid` is low, every entry is masked with all other fields zero, no pin is pending, and no in-service flag is set.
- R2: A write with `ent_we` high loads `ent_wdata` into entry `ent_idx`, using this layout: vector [7:0], delivery mode [10:8], destination mode [11], active-low polarity [12], level trigger [13] (1 = level, 0 = edge), mask [14] (1 = masked), destination [22:15]. A write leaves the entry's in-service flag unchanged. A write to an index at or above the pin count is discarded.
- R3: When the polarity bit is set, the line is inverted before any other processing: a low line is active.
- R4: Pin 2 is driven by the OR of line 0 and line 2. Pin 0 has no source and never becomes pending. Every other pin N is driven by line N.
- R5: On a level pin, the pending bit follows the conditioned line one cycle later, whether or not the pin is masked. A masked, pending level pin is delivered once it is unmasked.
- R6: On an edge pin, a rising conditioned line sets the pending bit only while the entry is unmasked. A request that arrives while the pin is masked is lost. Delivering an edge pin clears its pending bit, and a new request in the same cycle takes precedence over that clear.
- R7: Deliveries leave one at a time. The lowest-indexed pin that is pending, unmasked and not blocked is chosen first. A delivery is held with all fields stable until `dlv_ready` is high at a clock edge, and the next delivery may load in that same edge.
- R8: Delivering a level pin sets its in-service flag. A level pin whose flag is set is not delivered.
- R9: An end-of-interrupt with vector V clears the in-service flag of every entry whose flag is set and whose vector equals V. A pin that is still pending and unmasked is then delivered again. A flag being set by a delivery in the same cycle as a matching end-of-interrupt stays set.
- R10: When the delivery mode is 3'b111, the delivered vector is the value on `legacy_vector` in the cycle the delivery is loaded, and the entry's vector field is not used.
- R11: Each delivery carries the entry's destination, destination mode, delivery mode and trigger mode. Its vector is the entry's vector field, except in the case covered by R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_PINS | Raw interrupt request lines |
| ent_we | input | 1 | Redirection entry write strobe |
| ent_idx | input | IDX_W | Entry index for the write |
| ent_wdata | input | 23 | Entry contents (layout in R2) |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| legacy_vector | input | 8 | Vector supplied by the legacy controller |
| dlv_valid | output | 1 | Delivery message present |
| dlv_ready | input | 1 | Receiver accepts the delivery |
| dlv_dest | output | 8 | Destination field |
| dlv_dest_mode | output | 1 | Destination mode |
| dlv_mode | output | 3 | Delivery mode |
| dlv_vector | output | 8 | Delivered vector |
| dlv_level | output | 1 | 1 when the delivering pin is level-triggered |

## Verification
The hardest case to reach is an end-of-interrupt that arrives in exactly the same cycle as the delivery that sets the in-service flag for that vector. From the ports, this means timing the broadcast to land on the load edge. The bench gets there by holding a level line active on a masked pin, unmasking it with an entry write, and then asserting the matching end-of-interrupt on the very next cycle. That next edge is the load edge. The second case is a delivery held for several cycles while a second pin waits, which shows the scan order and that the output stays stable. The bench holds `dlv_ready` low while two edge lines fire together.

// File: rtl/irq_redir_pkg.sv
// Package: shared widths, entry layout and delivery payload for the
// interrupt redirection engine. Assumes an 8-bit vector and destination.
package irq_redir_pkg;
    localparam int VEC_W  = 8;
    localparam int DEST_W = 8;
    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] MODE_LEGACY = 3'b111;

    // Field order sets the bit layout of the write port (msb first).
    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              mask;
        logic              level;
        logic              active_low;
        logic              logical;
        logic [MODE_W-1:0] mode;
        logic [VEC_W-1:0]  vector;
    } redir_entry_t;

    localparam int ENTRY_W  = $bits(redir_entry_t);
    localparam int MASK_BIT = VEC_W + MODE_W + 3;

    // Part of an entry that travels with a delivery.
    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              logical;
        logic [MODE_W-1:0] mode;
        logic [VEC_W-1:0]  vector;
        logic              level;
    } dlv_payload_t;
endpackage

// File: rtl/irq_input_cond.sv
// Module: irq_input_cond
// Maps raw lines onto pins (line 0 joins line 2 on pin 2, pin 0 has no
// source), applies per-pin polarity and flags rising conditioned levels.
// Assumes lines are already synchronous to clk.
module irq_input_cond #(
    parameter int NUM_PINS = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] irq_in,
    input  logic [NUM_PINS-1:0] pol_vec,
    output logic [NUM_PINS-1:0] cond_lvl,
    output logic [NUM_PINS-1:0] cond_rise
);
    logic [NUM_PINS-1:0] raw_pin;
    logic [NUM_PINS-1:0] prev_q;

    // Line-to-pin routing, one choice per pin.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_route
        if (p == 0) begin : g_none
            assign raw_pin[p] = 1'b0;
        end else if (p == 2) begin : g_shared
            assign raw_pin[p] = irq_in[0] | irq_in[2];
        end else begin : g_direct
            assign raw_pin[p] = irq_in[p];
        end
    end

    assign cond_lvl  = raw_pin ^ pol_vec;
    assign cond_rise = cond_lvl & ~prev_q;

    // Remember last conditioned level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cond_lvl;
    end
endmodule

// File: rtl/irq_entry_table.sv
// Module: irq_entry_table
// Holds the redirection entries and the per-pin in-service flags.
// A delivery setting a flag beats an end-of-interrupt clearing it.
// Assumes at most one write per cycle; out-of-range writes are dropped.
module irq_entry_table
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = $clog2(NUM_PINS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [IDX_W-1:0]              idx,
    input  logic [ENTRY_W-1:0]            wdata,
    input  logic [NUM_PINS-1:0]           rirr_set,
    input  logic                          eoi_valid,
    input  logic [VEC_W-1:0]              eoi_vector,
    output logic [NUM_PINS-1:0]           mask_vec,
    output logic [NUM_PINS-1:0]           level_vec,
    output logic [NUM_PINS-1:0]           pol_vec,
    output logic [NUM_PINS-1:0]           rirr_vec,
    output dlv_payload_t [NUM_PINS-1:0]   payload_arr
);
    localparam logic [IDX_W:0]      PIN_LIMIT   = (IDX_W+1)'(NUM_PINS);
    localparam logic [ENTRY_W-1:0]  RESET_ENTRY = ENTRY_W'(1) << MASK_BIT;

    redir_entry_t        ent_q [NUM_PINS];
    logic [NUM_PINS-1:0] rirr_q;
    logic                wr_hit;

    assign wr_hit = we && ({1'b0, idx} < PIN_LIMIT);

    // Entry storage: reset to masked, load on an in-range write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PINS; p++) ent_q[p] <= redir_entry_t'(RESET_ENTRY);
        end else if (wr_hit) begin
            for (int p = 0; p < NUM_PINS; p++)
                if (idx == IDX_W'(p)) ent_q[p] <= redir_entry_t'(wdata);
        end
    end

    // In-service flags: set by level delivery, cleared by matching EOI.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rirr_q <= '0;
        end else begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (rirr_set[p])
                    rirr_q[p] <= 1'b1;
                else if (eoi_valid && rirr_q[p] && (ent_q[p].vector == eoi_vector))
                    rirr_q[p] <= 1'b0;
            end
        end
    end

    // Flatten entries into per-field vectors and delivery payloads.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_out
        assign mask_vec[p]             = ent_q[p].mask;
        assign level_vec[p]            = ent_q[p].level;
        assign pol_vec[p]              = ent_q[p].active_low;
        assign payload_arr[p].dest     = ent_q[p].dest;
        assign payload_arr[p].logical  = ent_q[p].logical;
        assign payload_arr[p].mode     = ent_q[p].mode;
        assign payload_arr[p].vector   = ent_q[p].vector;
        assign payload_arr[p].level    = ent_q[p].level;
    end
    assign rirr_vec = rirr_q;
endmodule

// File: rtl/irq_pending_ctl.sv
// Module: irq_pending_ctl
// Per-pin pending register. Level pins track the conditioned line; edge
// pins latch an unmasked rise and drop it when delivered (a new rise wins).
module irq_pending_ctl #(
    parameter int NUM_PINS = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] cond_lvl,
    input  logic [NUM_PINS-1:0] cond_rise,
    input  logic [NUM_PINS-1:0] mask_vec,
    input  logic [NUM_PINS-1:0] level_vec,
    input  logic [NUM_PINS-1:0] taken_vec,
    output logic [NUM_PINS-1:0] pend_vec
);
    logic [NUM_PINS-1:0] pend_q;
    logic [NUM_PINS-1:0] edge_next;
    logic [NUM_PINS-1:0] pend_d;

    // Next pending value by trigger type.
    always_comb begin
        edge_next = (pend_q & ~taken_vec) | (cond_rise & ~mask_vec);
        pend_d    = (level_vec & cond_lvl) | (~level_vec & edge_next);
    end

    // Pending register.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_vec = pend_q;
endmodule

// File: rtl/irq_dlv_stage.sv
// Module: irq_dlv_stage
// Picks the lowest eligible pin and holds one delivery on a valid/ready
// output. Legacy-mode deliveries take the vector from legacy_vector.
// Assumes payload_arr is stable within a cycle.
module irq_dlv_stage
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = $clog2(NUM_PINS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PINS-1:0]         elig_vec,
    input  dlv_payload_t [NUM_PINS-1:0] payload_arr,
    input  logic [VEC_W-1:0]            legacy_vector,
    input  logic                        dlv_ready,
    output logic                        dlv_valid,
    output dlv_payload_t                dlv_out,
    output logic [NUM_PINS-1:0]         take_vec
);
    logic             found;
    logic [IDX_W-1:0] pick_idx;
    logic             load;
    logic             valid_q;
    dlv_payload_t     sel;
    dlv_payload_t     out_q;

    // Lowest-index eligible pin.
    always_comb begin
        found    = 1'b0;
        pick_idx = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (elig_vec[i]) begin
                found    = 1'b1;
                pick_idx = IDX_W'(i);
            end
        end
    end

    assign load = found && (!valid_q || dlv_ready);

    // One-hot of the pin loaded this cycle.
    always_comb begin
        for (int i = 0; i < NUM_PINS; i++)
            take_vec[i] = load && (pick_idx == IDX_W'(i));
    end

    // Payload of the chosen pin with vector source resolved.
    always_comb begin
        sel = payload_arr[pick_idx];
        if (sel.mode == MODE_LEGACY) sel.vector = legacy_vector;
    end

    // Output holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            out_q   <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            out_q   <= sel;
        end else if (dlv_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign dlv_valid = valid_q;
    assign dlv_out   = out_q;
endmodule

// File: rtl/irq_redirect_engine.sv
// Module: irq_redirect_engine (top)
// Conditions interrupt lines, tracks pending pins and in-service flags,
// and issues one delivery at a time. Entries come from a plain write port.
// Assumes all inputs synchronous to clk.
module irq_redirect_engine
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = $clog2(NUM_PINS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PINS-1:0]  irq_in,
    input  logic                 ent_we,
    input  logic [IDX_W-1:0]     ent_idx,
    input  logic [ENTRY_W-1:0]   ent_wdata,
    input  logic                 eoi_valid,
    input  logic [VEC_W-1:0]     eoi_vector,
    input  logic [VEC_W-1:0]     legacy_vector,
    output logic                 dlv_valid,
    input  logic                 dlv_ready,
    output logic [DEST_W-1:0]    dlv_dest,
    output logic                 dlv_dest_mode,
    output logic [MODE_W-1:0]    dlv_mode,
    output logic [VEC_W-1:0]     dlv_vector,
    output logic                 dlv_level
);
    logic [NUM_PINS-1:0]         mask_vec, level_vec, pol_vec, rirr_vec;
    logic [NUM_PINS-1:0]         cond_lvl, cond_rise, pend_vec, elig_vec, take_vec;
    dlv_payload_t [NUM_PINS-1:0] payload_arr;
    dlv_payload_t                dlv_out;

    irq_entry_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n), .we(ent_we), .idx(ent_idx), .wdata(ent_wdata),
        .rirr_set(take_vec & level_vec), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .mask_vec(mask_vec), .level_vec(level_vec), .pol_vec(pol_vec),
        .rirr_vec(rirr_vec), .payload_arr(payload_arr)
    );

    irq_input_cond #(.NUM_PINS(NUM_PINS)) u_cond (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .pol_vec(pol_vec),
        .cond_lvl(cond_lvl), .cond_rise(cond_rise)
    );

    irq_pending_ctl #(.NUM_PINS(NUM_PINS)) u_pend (
        .clk(clk), .rst_n(rst_n), .cond_lvl(cond_lvl), .cond_rise(cond_rise),
        .mask_vec(mask_vec), .level_vec(level_vec), .taken_vec(take_vec),
        .pend_vec(pend_vec)
    );

    // Pending, unmasked, and not a level pin awaiting end-of-interrupt.
    assign elig_vec = pend_vec & ~mask_vec & ~(level_vec & rirr_vec);

    irq_dlv_stage #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_dlv (
        .clk(clk), .rst_n(rst_n), .elig_vec(elig_vec), .payload_arr(payload_arr),
        .legacy_vector(legacy_vector), .dlv_ready(dlv_ready),
        .dlv_valid(dlv_valid), .dlv_out(dlv_out), .take_vec(take_vec)
    );

    assign dlv_dest      = dlv_out.dest;
    assign dlv_dest_mode = dlv_out.logical;
    assign dlv_mode      = dlv_out.mode;
    assign dlv_vector    = dlv_out.vector;
    assign dlv_level     = dlv_out.level;
endmodule

// File: rtl/irq_redirect_engine_checker.sv
// Module: irq_redirect_engine_checker
// Temporal properties of the redirection engine, bound into the top.
module irq_redirect_engine_checker
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                dlv_valid,
    input logic                dlv_ready,
    input logic [DEST_W-1:0]   dlv_dest,
    input logic                dlv_dest_mode,
    input logic [MODE_W-1:0]   dlv_mode,
    input logic [VEC_W-1:0]    dlv_vector,
    input logic                dlv_level,
    input logic [VEC_W-1:0]    legacy_vector,
    input logic [NUM_PINS-1:0] take_vec,
    input logic [NUM_PINS-1:0] level_vec,
    input logic [NUM_PINS-1:0] rirr_vec
);
    a_r1_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> !dlv_valid);

    a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_vector) && $stable(dlv_dest)
            && $stable(dlv_mode) && $stable(dlv_dest_mode) && $stable(dlv_level));

    a_r7_single_take: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take_vec));

    a_r8_no_repeat_level: assert property (@(posedge clk) disable iff (!rst_n)
        (take_vec & level_vec & rirr_vec) == '0);

    a_r10_legacy_vector: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dlv_valid) && (dlv_mode == MODE_LEGACY) |-> dlv_vector == $past(legacy_vector));
endmodule

bind irq_redirect_engine irq_redirect_engine_checker #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
    .dlv_dest(dlv_dest), .dlv_dest_mode(dlv_dest_mode), .dlv_mode(dlv_mode),
    .dlv_vector(dlv_vector), .dlv_level(dlv_level), .legacy_vector(legacy_vector),
    .take_vec(take_vec), .level_vec(level_vec), .rirr_vec(rirr_vec)
);

// File: tb/irq_redirect_engine_test.sv
module irq_redirect_engine_test;
    localparam int NP = 24;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] irq_in = '0;
    logic          ent_we = 1'b0;
    logic [IW-1:0] ent_idx = '0;
    logic [22:0]   ent_wdata = '0;
    logic          eoi_valid = 1'b0;
    logic [7:0]    eoi_vector = '0;
    logic [7:0]    legacy_vector = 8'h77;
    logic          dlv_ready = 1'b1;
    logic          dlv_valid, dlv_dest_mode, dlv_level;
    logic [7:0]    dlv_dest, dlv_vector;
    logic [2:0]    dlv_mode;

    int checks = 0;
    int errors = 0;

    irq_redirect_engine #(.NUM_PINS(NP)) uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ent_we(ent_we), .ent_idx(ent_idx),
        .ent_wdata(ent_wdata), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .legacy_vector(legacy_vector), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
        .dlv_dest(dlv_dest), .dlv_dest_mode(dlv_dest_mode), .dlv_mode(dlv_mode),
        .dlv_vector(dlv_vector), .dlv_level(dlv_level)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference: entries, pending, in-service, output slot.
    logic [22:0] m_ent [NP];
    bit          m_pend [NP];
    bit          m_rirr [NP];
    bit          m_prev [NP];
    bit          m_valid;
    logic [7:0]  m_vec, m_dest;
    logic [2:0]  m_mode;
    bit          m_logical, m_lvl;

    always @(posedge clk) begin
        bit c [NP];
        bit raw;
        int pick;
        logic [22:0] e;
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin
                m_ent[p] = 23'h004000; m_pend[p] = 0; m_rirr[p] = 0; m_prev[p] = 0;
            end
            m_valid = 0; m_vec = 0; m_dest = 0; m_mode = 0; m_logical = 0; m_lvl = 0;
        end else begin
            for (int p = 0; p < NP; p++) begin
                if (p == 0) raw = 0;
                else if (p == 2) raw = irq_in[0] | irq_in[2];
                else raw = irq_in[p];
                c[p] = raw ^ m_ent[p][12];
            end
            pick = -1;
            if (!m_valid || dlv_ready)
                for (int p = 0; p < NP; p++)
                    if (pick < 0 && m_pend[p] && !m_ent[p][14] && !(m_ent[p][13] && m_rirr[p]))
                        pick = p;
            for (int p = 0; p < NP; p++) begin
                if (m_ent[p][13]) m_pend[p] = c[p];
                else m_pend[p] = (m_pend[p] && pick != p) || (c[p] && !m_prev[p] && !m_ent[p][14]);
                if (pick == p && m_ent[p][13]) m_rirr[p] = 1;
                else if (eoi_valid && m_rirr[p] && m_ent[p][7:0] == eoi_vector) m_rirr[p] = 0;
                m_prev[p] = c[p];
            end
            if (pick >= 0) begin
                e = m_ent[pick];
                m_valid = 1;
                m_vec = (e[10:8] == 3'b111) ? legacy_vector : e[7:0];
                m_dest = e[22:15]; m_mode = e[10:8]; m_logical = e[11]; m_lvl = e[13];
            end else if (dlv_ready) begin
                m_valid = 0;
            end
            if (ent_we && ent_idx < NP) m_ent[ent_idx] = ent_wdata;
        end
    end

    // Every-cycle comparison against the reference.
    always @(negedge clk) begin
        if ($time > 10) begin
            chk(dlv_valid == m_valid, "R7 model valid", dlv_valid, m_valid);
            if (m_valid)
                chk({dlv_dest, dlv_dest_mode, dlv_mode, dlv_vector, dlv_level} ==
                    {m_dest, m_logical, m_mode, m_vec, m_lvl}, "R11 model fields",
                    {dlv_dest, dlv_vector}, {m_dest, m_vec});
        end
    end

    function automatic logic [22:0] mk(input logic [7:0] vec, input logic [2:0] mode,
        input bit logical, input bit pol, input bit lvl, input bit msk, input logic [7:0] dest);
        return {dest, msk, lvl, pol, logical, mode, vec};
    endfunction

    task automatic wr(input int idx, input logic [22:0] d);
        ent_we = 1; ent_idx = IW'(idx); ent_wdata = d;
        @(negedge clk);
        ent_we = 0;
    endtask

    task automatic pulse(input int line);
        irq_in[line] = 1;
        @(negedge clk);
        irq_in[line] = 0;
    endtask

    task automatic eoi(input logic [7:0] v);
        eoi_valid = 1; eoi_vector = v;
        @(negedge clk);
        eoi_valid = 0;
    endtask

    task automatic expect_dlv(input string tag, input logic [7:0] vec, input logic [7:0] dest,
                              input bit lvl, input logic [2:0] mode);
        bit seen = 0;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            seen = dlv_valid;
        end
        chk(seen, {tag, " delivery seen"}, seen, 1);
        chk(dlv_vector == vec, {tag, " vector"}, dlv_vector, vec);
        chk(dlv_dest == dest, {tag, " R11 dest"}, dlv_dest, dest);
        chk(dlv_level == lvl && dlv_mode == mode, {tag, " R11 trig/mode"},
            {dlv_level, dlv_mode}, {lvl, mode});
    endtask

    task automatic expect_none(input string tag, input int n);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (dlv_valid) seen = 1;
        end
        chk(!seen, {tag, " no delivery"}, seen, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        irq_in[3] = 1;
        repeat (4) @(negedge clk);
        rst_n = 1;
        chk(!dlv_valid, "R1 reset valid", dlv_valid, 0);
        expect_none("R1 masked after reset", 6);
        irq_in[3] = 0;

        // Edge pin, unmasked
        wr(5, mk(8'h35, 3'd0, 1, 0, 0, 0, 8'h11));
        pulse(5);
        expect_dlv("R6 R2 edge pin5", 8'h35, 8'h11, 0, 3'd0);
        expect_none("R6 edge consumed", 8);

        // Edge request while masked is lost
        wr(6, mk(8'h36, 3'd1, 0, 0, 0, 1, 8'h12));
        pulse(6);
        wr(6, mk(8'h36, 3'd1, 0, 0, 0, 0, 8'h12));
        expect_none("R6 masked edge dropped", 8);

        // Active-low edge pin
        wr(7, mk(8'h37, 3'd0, 0, 1, 0, 1, 8'h13));
        repeat (2) @(negedge clk);
        wr(7, mk(8'h37, 3'd0, 0, 1, 0, 0, 8'h13));
        expect_none("R3 no spurious edge", 4);
        irq_in[7] = 1;
        repeat (2) @(negedge clk);
        irq_in[7] = 0;
        expect_dlv("R3 low-active edge", 8'h37, 8'h13, 0, 3'd0);
        irq_in[7] = 1;

        // Routing of lines 0 and 2
        wr(2, mk(8'h42, 3'd0, 0, 0, 0, 0, 8'h02));
        wr(0, mk(8'h40, 3'd0, 0, 0, 0, 0, 8'h00));
        pulse(0);
        expect_dlv("R4 line0 to pin2", 8'h42, 8'h02, 0, 3'd0);
        expect_none("R4 pin0 silent", 6);
        pulse(2);
        expect_dlv("R4 line2 to pin2", 8'h42, 8'h02, 0, 3'd0);

        // Ascending order and hold under back-pressure
        wr(4, mk(8'h44, 3'd0, 0, 0, 0, 0, 8'h04));
        wr(9, mk(8'h49, 3'd0, 0, 0, 0, 0, 8'h09));
        dlv_ready = 0;
        irq_in[4] = 1; irq_in[9] = 1;
        @(negedge clk);
        irq_in[4] = 0; irq_in[9] = 0;
        expect_dlv("R7 lowest first", 8'h44, 8'h04, 0, 3'd0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(dlv_valid && dlv_vector == 8'h44, "R7 held while stalled", dlv_vector, 8'h44);
        end
        dlv_ready = 1;
        expect_dlv("R7 next after accept", 8'h49, 8'h09, 0, 3'd0);

        // Level pin and end-of-interrupt
        wr(10, mk(8'h5A, 3'd1, 1, 0, 1, 0, 8'h22));
        irq_in[10] = 1;
        expect_dlv("R8 level pin10", 8'h5A, 8'h22, 1, 3'd1);
        expect_none("R8 blocked while in service", 10);
        wr(10, mk(8'h5A, 3'd1, 1, 0, 1, 0, 8'h22));
        expect_none("R2 write keeps in-service", 6);
        eoi(8'h5B);
        expect_none("R9 other vector", 6);
        eoi(8'h5A);
        expect_dlv("R9 redeliver after EOI", 8'h5A, 8'h22, 1, 3'd1);
        irq_in[10] = 0;
        repeat (2) @(negedge clk);
        eoi(8'h5A);
        expect_none("R5 level dropped", 8);

        // Masked level pin delivered on unmask
        wr(11, mk(8'h5C, 3'd0, 0, 0, 1, 1, 8'h33));
        irq_in[11] = 1;
        expect_none("R5 masked level held", 4);
        wr(11, mk(8'h5C, 3'd0, 0, 0, 1, 0, 8'h33));
        expect_dlv("R5 unmask level", 8'h5C, 8'h33, 1, 3'd0);
        irq_in[11] = 0;
        repeat (2) @(negedge clk);
        eoi(8'h5C);

        // Legacy-mode vector source
        wr(12, mk(8'h01, 3'b111, 0, 0, 0, 0, 8'h44));
        pulse(12);
        expect_dlv("R10 legacy vector", 8'h77, 8'h44, 0, 3'b111);

        // EOI on the same edge as the level delivery
        wr(13, mk(8'h66, 3'd0, 0, 0, 1, 1, 8'h55));
        irq_in[13] = 1;
        repeat (2) @(negedge clk);
        wr(13, mk(8'h66, 3'd0, 0, 0, 1, 0, 8'h55));
        eoi(8'h66);
        chk(dlv_valid && dlv_vector == 8'h66, "R9 delivery on EOI edge", dlv_vector, 8'h66);
        expect_none("R9 set beats clear", 8);
        irq_in[13] = 0;
        repeat (2) @(negedge clk);
        eoi(8'h66);
        expect_none("R9 cleanup", 4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule